// File: doc/BRIEF.md
# Four-Channel Burst DMA Engine

A memory-to-memory copy engine with four independent channels. Software programs each channel through a small register port with a source address, a destination address, a 16-bit byte count and a control word. Setting the control word's enable bit starts the channel. The engine does not finish one channel before it moves on. It serves active channels in turns, one bounded burst per service tick, and picks them round-robin. After every burst it writes the current addresses and the remaining count back into the channel registers. Software can therefore watch a long copy make progress, and no single channel can hold the memory port.

Within a burst, the engine moves 32-bit words while at least four bytes remain and single bytes after that. A memory access is a request held until it is acknowledged. Each access carries an address-space tag, which an external lookup returns for the current source or destination address. When a channel's count reaches zero, the engine clears that channel's enable and busy bits and emits a one-cycle completion pulse that a descriptor fetcher can use. Unless that channel masks it, the engine also sets the channel's bit in a shared interrupt state register.

Top module: `dma4_burst`

## Requirements
- R1: After reset every channel register and the interrupt state read zero, `irq`, `mem_req` and `done_valid` are low. Register addresses: channel c field f sits at c*4+f, with f=0 source, 1 destination, 2 count (byte count in bits 15:0) and 3 control. Address 16 is the interrupt state.
- R2: A channel starts only when a control write takes bit 12 from 0 to 1 while that channel is not already active. A control write with bit 12 clear moves no data. A channel started with a zero byte count completes without any memory access.
- R3: Control bit 14 cannot be changed by a register write and keeps its old value. Bits 12 and 14 both read 1 while the channel is being served.
- R4: Each transfer reads the source and then writes the destination. It is a word (`mem_word`=1, 4 bytes, little-endian) while at least 4 bytes remain, otherwise a single byte. Both addresses advance by the transfer size, and the copied bytes equal the source bytes.
- R5: One burst makes at most 32 transfers. After each burst the source, destination and the low 16 count bits are written back to the channel registers, and count bits 31:16 keep their value.
- R6: On each service tick the search starts at the channel after the one served last (channel 0 after reset), wraps modulo 4, and serves the first channel that is both active and enabled.
- R7: On completion the engine clears control bits 12 and 14 and sets interrupt state bit 4+channel, unless control bit 10 is set. `irq` is high while any interrupt state bit is set. Writing 1 to a bit at address 16 clears it.
- R8: `mem_space` equals the lookup result for the source address during reads and for the destination address during writes.
- R9: The service tick stops while no channel is active. The first channel to start is served in the next cycle, so `mem_req` is high in the second cycle after the starting write.
- R10: Completion gives a single-cycle `done_valid` with `done_ch` naming the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW (5) | Register address |
| reg_wdata | input | W (32) | Register write data |
| reg_rdata | output | W (32) | Register read data (combinational) |
| src_look_addr | output | W (32) | Source address sent to the space lookup |
| src_look_space | input | SW (2) | Space returned for the source address |
| dst_look_addr | output | W (32) | Destination address sent to the space lookup |
| dst_look_space | input | SW (2) | Space returned for the destination address |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 32-bit word, 0 = single byte |
| mem_addr | output | W (32) | Byte address of the access |
| mem_space | output | SW (2) | Space tag of the access |
| mem_wdata | output | W (32) | Write data (byte in bits 7:0) |
| mem_rdata | input | W (32) | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access accepted |
| done_valid | output | 1 | One-cycle channel completion pulse |
| done_ch | output | 2 | Channel that completed |
| irq | output | 1 | OR of the interrupt state bits |

## Verification
A corrupted arbitration pointer shows up as a different order of the source regions read on the memory port, visible within one burst of about 128 cycles. Wrong step or size bookkeeping shows up in the copied bytes and in the count read back after the first burst, and a lost busy or enable bit shows up when software reads the control word during a burst. A missed completion shows within a few cycles as `irq` staying low or `done_valid` never pulsing, and a service tick that is never re-armed shows up at once because `mem_req` stays low in the second cycle after a start.

// File: rtl/dma4_burst.sv
module dma4_burst #(
  parameter int NCH         = 4,
  parameter int W           = 32,
  parameter int SW          = 2,
  parameter int BURST       = 32,
  parameter int TICK_CYCLES = 16,
  parameter int IRQ_BASE    = 4,
  parameter int RAW         = $clog2(NCH) + 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [RAW-1:0]         reg_addr,
  input  logic [W-1:0]           reg_wdata,
  output logic [W-1:0]           reg_rdata,
  output logic [W-1:0]           src_look_addr,
  input  logic [SW-1:0]          src_look_space,
  output logic [W-1:0]           dst_look_addr,
  input  logic [SW-1:0]          dst_look_space,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic                   mem_word,
  output logic [W-1:0]           mem_addr,
  output logic [SW-1:0]          mem_space,
  output logic [W-1:0]           mem_wdata,
  input  logic [W-1:0]           mem_rdata,
  input  logic                   mem_ack,
  output logic                   done_valid,
  output logic [$clog2(NCH)-1:0] done_ch,
  output logic                   irq
);
  localparam int CHW = $clog2(NCH);
  localparam int BW  = $clog2(BURST + 1);
  localparam int TW  = $clog2(TICK_CYCLES + 1);
  localparam int EN  = 12;
  localparam int ACT = 14;
  localparam int MSK = 10;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_WB} state_t;

  logic [W-1:0]   src_r [NCH];
  logic [W-1:0]   dst_r [NCH];
  logic [W-1:0]   cnt_r [NCH];
  logic [W-1:0]   ctrl_r[NCH];
  logic [NCH-1:0] active;
  logic [CHW-1:0] last_ch;
  logic [W-1:0]   int_r;

  state_t         state;
  logic [CHW-1:0] cur_ch;
  logic [W-1:0]   cur_src, cur_dst, buf_q;
  logic [15:0]    cur_cnt;
  logic [BW-1:0]  beats;
  logic [TW-1:0]  tick_cnt;

  logic           tick, found, word, serving, cur_act;
  logic [CHW-1:0] grant;
  logic [15:0]    step;
  logic           sel_int;
  logic [CHW-1:0] wr_ch;
  logic [1:0]     wr_fld;

  assign sel_int = reg_addr[RAW-1];
  assign wr_ch   = reg_addr[RAW-2:2];
  assign wr_fld  = reg_addr[1:0];

  always_comb begin
    reg_rdata = '0;
    if (sel_int) reg_rdata = int_r;
    else begin
      case (wr_fld)
        2'd0: reg_rdata = src_r[wr_ch];
        2'd1: reg_rdata = dst_r[wr_ch];
        2'd2: reg_rdata = cnt_r[wr_ch];
        default: reg_rdata = ctrl_r[wr_ch];
      endcase
    end
  end

  always_comb begin
    found = 1'b0;
    grant = '0;
    for (int i = 1; i <= NCH; i++) begin
      int k;
      k = (int'(last_ch) + i) % NCH;
      if (!found && active[k] && ctrl_r[k][EN]) begin
        found = 1'b1;
        grant = CHW'(k);
      end
    end
  end

  assign tick    = (tick_cnt == '0) && (|active) && (state == S_IDLE);
  assign word    = cur_cnt >= 16'd4;
  assign step    = word ? 16'd4 : 16'd1;
  assign serving = state != S_IDLE;
  assign cur_act = ctrl_r[cur_ch][ACT];

  assign src_look_addr = cur_src;
  assign dst_look_addr = cur_dst;
  assign mem_req    = (state == S_RD) || (state == S_WR);
  assign mem_we     = state == S_WR;
  assign mem_word   = word;
  assign mem_addr   = (state == S_WR) ? cur_dst : cur_src;
  assign mem_space  = (state == S_WR) ? dst_look_space : src_look_space;
  assign mem_wdata  = buf_q;
  assign done_valid = (state == S_WB) && (cur_cnt == 16'd0);
  assign done_ch    = cur_ch;
  assign irq        = |int_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt <= '0;
    else if (active == '0) tick_cnt <= '0;
    else if (tick) tick_cnt <= TW'(TICK_CYCLES - 1);
    else if (tick_cnt != '0) tick_cnt <= tick_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_ch  <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
      buf_q   <= '0;
      beats   <= '0;
    end else begin
      case (state)
        S_IDLE: if (tick && found) begin
          cur_ch  <= grant;
          cur_src <= src_r[grant];
          cur_dst <= dst_r[grant];
          cur_cnt <= cnt_r[grant][15:0];
          beats   <= '0;
          state   <= (cnt_r[grant][15:0] == 16'd0) ? S_WB : S_RD;
        end
        S_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= S_WR;
        end
        S_WR: if (mem_ack) begin
          cur_src <= cur_src + W'(step);
          cur_dst <= cur_dst + W'(step);
          cur_cnt <= cur_cnt - step;
          beats   <= beats + 1'b1;
          state   <= (cur_cnt == step || beats == BW'(BURST - 1)) ? S_WB : S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        src_r[c]  <= '0;
        dst_r[c]  <= '0;
        cnt_r[c]  <= '0;
        ctrl_r[c] <= '0;
      end
      active  <= '0;
      last_ch <= CHW'(NCH - 1);
      int_r   <= '0;
    end else begin
      if (reg_wr && sel_int) int_r <= int_r & ~reg_wdata;
      if (reg_wr && !sel_int) begin
        case (wr_fld)
          2'd0: src_r[wr_ch] <= reg_wdata;
          2'd1: dst_r[wr_ch] <= reg_wdata;
          2'd2: cnt_r[wr_ch] <= reg_wdata;
          default: begin
            ctrl_r[wr_ch]      <= reg_wdata;
            ctrl_r[wr_ch][ACT] <= ctrl_r[wr_ch][ACT];
            if (!ctrl_r[wr_ch][EN] && reg_wdata[EN] && !active[wr_ch])
              active[wr_ch] <= 1'b1;
          end
        endcase
      end
      if (state == S_IDLE && tick && found) begin
        ctrl_r[grant][EN]  <= 1'b1;
        ctrl_r[grant][ACT] <= 1'b1;
        last_ch <= grant;
      end
      if (state == S_WB) begin
        src_r[cur_ch] <= cur_src;
        dst_r[cur_ch] <= cur_dst;
        cnt_r[cur_ch] <= {cnt_r[cur_ch][W-1:16], cur_cnt};
        if (cur_cnt == 16'd0) begin
          ctrl_r[cur_ch][EN]  <= 1'b0;
          ctrl_r[cur_ch][ACT] <= 1'b0;
          active[cur_ch]      <= 1'b0;
          if (!ctrl_r[cur_ch][MSK]) int_r[IRQ_BASE + int'(cur_ch)] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma4_burst_chk.sv
module dma4_burst_chk #(
  parameter int NCH   = 4,
  parameter int BURST = 32,
  parameter int BW    = 6,
  parameter int W     = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_ack,
  input logic           mem_we,
  input logic [W-1:0]   mem_addr,
  input logic [BW-1:0]  beats,
  input logic           serving,
  input logic           cur_act,
  input logic [NCH-1:0] active,
  input logic           done_valid,
  input logic           irq
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    beats <= BW'(BURST)); // R5
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    serving |-> cur_act); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R10
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_valid)); // R7
  AST_SERVE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    serving |-> (active != '0)); // R9
endmodule

bind dma4_burst dma4_burst_chk #(.NCH(NCH), .BURST(BURST), .BW(BW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .beats(beats), .serving(serving), .cur_act(cur_act),
  .active(active), .done_valid(done_valid), .irq(irq)
);

// File: tb/test_dma4_burst.sv
module test_dma4_burst;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] src_look_addr, dst_look_addr;
  logic [1:0]  src_look_space, dst_look_space;
  logic        mem_req, mem_we, mem_word, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_space;
  logic        done_valid, irq;
  logic [1:0]  done_ch;

  int errors = 0;
  int checks = 0;

  logic [7:0] m0 [1024];
  logic [7:0] m1 [1024];
  logic       ack_r = 1'b0;
  logic [31:0] rdata_r = '0;
  int space_bad = 0;
  bit  log_on = 0;
  int  log_n = 0;
  int  log_ch [8];
  int  log_prev = -1;

  assign src_look_space = {1'b0, src_look_addr[12]};
  assign dst_look_space = {1'b0, dst_look_addr[12]};
  assign mem_ack   = ack_r;
  assign mem_rdata = rdata_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma4_burst i_dma4_burst (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_look_addr(src_look_addr), .src_look_space(src_look_space),
    .dst_look_addr(dst_look_addr), .dst_look_space(dst_look_space),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_space(mem_space), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .done_valid(done_valid), .done_ch(done_ch), .irq(irq)
  );

  function automatic logic [7:0] rdb(logic [31:0] a);
    return a[12] ? m1[a[9:0]] : m0[a[9:0]];
  endfunction

  always @(posedge clk) begin
    if (mem_req && !ack_r) begin
      ack_r <= 1'b1;
      if (mem_space != {1'b0, mem_addr[12]}) space_bad++;
      if (!mem_we) begin
        if (log_on && int'(mem_addr[9]) != log_prev) begin
          log_prev = int'(mem_addr[9]);
          if (log_n < 8) log_ch[log_n] = log_prev;
          log_n++;
        end
        if (mem_word)
          rdata_r <= {rdb(mem_addr+3), rdb(mem_addr+2), rdb(mem_addr+1), rdb(mem_addr)};
        else
          rdata_r <= {24'h0, rdb(mem_addr)};
      end else begin
        for (int b = 0; b < (mem_word ? 4 : 1); b++) begin
          logic [31:0] a;
          a = mem_addr + 32'(b);
          if (a[12]) m1[a[9:0]] = mem_wdata[8*b +: 8];
          else       m0[a[9:0]] = mem_wdata[8*b +: 8];
        end
      end
    end else ack_r <= 1'b0;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = 5'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output int ch);
    ch = -1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (done_valid) begin ch = int'(done_ch); break; end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bit ok = 1;
    for (int a = 0; a <= 16; a++) begin
      rd(a, d);
      if (d != 0) ok = 0;
    end
    chk(ok, "R1 registers zero", {31'b0, ok}, 1);
    chk(!irq && !mem_req && !done_valid, "R1 outputs low", {29'b0, irq, mem_req, done_valid}, 0);
  endtask

  task automatic t_bytes;
    logic [31:0] d;
    int ch;
    bit ok = 1;
    m1[10'h08A] = 8'hEE;
    wr(0, 32'h0000_0040); wr(1, 32'h0000_1080); wr(2, 32'd10);
    wr(3, 32'h0000_1000);
    @(negedge clk);
    chk(mem_req, "R9 start serviced next cycle", {31'b0, mem_req}, 1);
    rd(3, d);
    chk(d[12] && d[14], "R3 enable and busy set while served", d, 32'h5000);
    wait_done(ch);
    chk(ch == 0, "R10 done_ch", 32'(ch), 0);
    for (int i = 0; i < 10; i++) if (m1[10'h080 + i] != m0[10'h040 + i]) ok = 0;
    chk(ok, "R4 copied bytes", {31'b0, ok}, 1);
    chk(m1[10'h08A] == 8'hEE, "R4 byte past end untouched", {24'b0, m1[10'h08A]}, 32'hEE);
    @(negedge clk);
    rd(0, d); chk(d == 32'h4A, "R4 source advanced", d, 32'h4A);
    rd(1, d); chk(d == 32'h108A, "R4 destination advanced", d, 32'h108A);
    rd(3, d); chk(d[12] == 0 && d[14] == 0, "R7 control bits cleared", d, 0);
    rd(16, d); chk(d == 32'h10, "R7 interrupt bit 4", d, 32'h10);
    chk(irq, "R7 irq high", {31'b0, irq}, 1);
    chk(space_bad == 0, "R8 space tags", 32'(space_bad), 0);
    wr(16, 32'h10);
    rd(16, d); chk(d == 0 && !irq, "R7 write-one clear", d, 0);
  endtask

  task automatic t_writeback;
    logic [31:0] d;
    int ch;
    bit ok = 1;
    wr(8, 32'h0000_0300); wr(9, 32'h0000_1300); wr(10, 32'hABCD_00C8);
    wr(11, 32'h0000_1000);
    d = 32'h00C8;
    for (int i = 0; i < 2000 && d[15:0] == 16'hC8; i++) begin
      @(negedge clk); rd(10, d);
    end
    chk(d == 32'hABCD_0048, "R5 count after first burst", d, 32'hABCD_0048);
    rd(8, d); chk(d == 32'h380, "R5 source after first burst", d, 32'h380);
    rd(9, d); chk(d == 32'h1380, "R5 destination after first burst", d, 32'h1380);
    wait_done(ch);
    chk(ch == 2, "R10 done_ch channel 2", 32'(ch), 2);
    @(negedge clk);
    rd(10, d); chk(d == 32'hABCD_0000, "R5 upper count bits kept", d, 32'hABCD_0000);
    for (int i = 0; i < 200; i++) if (m1[10'h300 + i] != m0[10'h300 + i]) ok = 0;
    chk(ok, "R4 long copy data", {31'b0, ok}, 1);
    rd(16, d); chk(d == 32'h40, "R7 interrupt bit 6", d, 32'h40);
    wr(16, 32'h40);
  endtask

  task automatic t_round_robin;
    logic [31:0] d;
    int ch;
    bit ok = 1;
    log_on = 1; log_n = 0; log_prev = -1;
    wr(0, 32'h0000_0000); wr(1, 32'h0000_1000); wr(2, 32'd256);
    wr(4, 32'h0000_0200); wr(5, 32'h0000_1200); wr(6, 32'd256);
    wr(3, 32'h0000_1000);
    wr(7, 32'h0000_1000);
    wait_done(ch);
    wait_done(ch);
    log_on = 0;
    chk(log_n == 4, "R6 burst count", 32'(log_n), 4);
    chk(log_ch[0] == 0 && log_ch[1] == 1 && log_ch[2] == 0 && log_ch[3] == 1,
        "R6 alternating order", {log_ch[0][7:0], log_ch[1][7:0], log_ch[2][7:0], log_ch[3][7:0]}, 32'h00010001);
    for (int i = 0; i < 256; i++) begin
      if (m1[i] != m0[i]) ok = 0;
      if (m1[10'h200 + i] != m0[10'h200 + i]) ok = 0;
    end
    chk(ok, "R6 both channels copied", {31'b0, ok}, 1);
    @(negedge clk);
    rd(16, d); chk(d == 32'h30, "R7 interrupt bits 4 and 5", d, 32'h30);
    wr(16, 32'h30);
  endtask

  task automatic t_mask_and_zero;
    logic [31:0] d;
    int ch;
    int reqs = 0;
    wr(12, 32'h0000_03E0); wr(13, 32'h0000_13E0); wr(14, 32'd8);
    wr(15, 32'h0000_1400);
    wait_done(ch);
    chk(ch == 3, "R10 done_ch channel 3", 32'(ch), 3);
    @(negedge clk);
    rd(16, d); chk(d == 0 && !irq, "R7 masked completion", d, 0);
    rd(15, d); chk(d[12] == 0 && d[14] == 0 && d[10], "R7 masked control", d, 32'h400);
    wr(2, 32'd0);
    wr(3, 32'h0000_1000);
    for (int i = 0; i < 6 && !done_valid; i++) begin
      if (mem_req) reqs++;
      @(negedge clk);
    end
    chk(done_valid && reqs == 0, "R2 zero count completes without access", 32'(reqs), 0);
    @(negedge clk);
    rd(16, d); chk(d == 32'h10, "R2 zero count interrupt", d, 32'h10);
    wr(16, 32'h10);
  endtask

  task automatic t_no_start;
    logic [31:0] d;
    int reqs = 0;
    wr(12, 32'h0000_0100); wr(14, 32'd16);
    wr(15, 32'h0000_4000);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    chk(reqs == 0, "R2 no start without enable edge", 32'(reqs), 0);
    rd(15, d); chk(d[14] == 0, "R3 busy bit not writable", d, 0);
    rd(14, d); chk(d == 32'd16, "R2 count untouched", d, 16);
    chk(space_bad == 0, "R8 space tags overall", 32'(space_bad), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      m0[i] = 8'(i * 7 + 3);
      m1[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_writeback();
    t_round_robin();
    t_mask_and_zero();
    t_no_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule